// File: doc/BRIEF.md
# Bit-Reversed FFT Frame Distributor

This block is the address sequencer for moving one 1024-point complex frame between a shared buffer and the local memories of 8 processing lanes. The shared buffer always holds the frame in plain natural order. Each lane holds 128 points of the frame, and the lane memories keep their contents in bit-reversed order. The block produces one address triple per sample: a shared-buffer address, a lane index and a local offset. The data path and the memories sit outside the block and use these addresses.

A transfer begins with a start pulse. The direction input selects one of two walks:

- **Scatter** walks the shared buffer in natural order. For each shared index n, it computes the bit reversal r of n. The destination is lane r[9:7] at local offset r[6:0].
- **Gather** walks the lane memories in order: lane 0 offsets 0 to 127, then lane 1, and so on. Each lane position k is sent to shared index bitrev(k).

Both walks use the same placement. Results gathered after a forward transform therefore land in natural order. Data scattered before an inverse transform lands in the layout that the inverse transform expects, so no separate reorder pass is needed.

A frame base, captured at start, offsets every shared address. This lets several frames sit back to back in the shared buffer. Each sample is offered with a valid/ready handshake, and a done pulse ends the transfer.

Top module: `bitrev_distributor`

## Requirements
- R1: After reset, valid_o and done_o are 0 and the block is idle until a start pulse.
- R2: In scatter (dir_i=0), the k-th accepted sample (k = 0..1023) has shared_addr_o = base + k. lane_o is bits [9:7] and offset_o is bits [6:0] of the 10-bit bit reversal of k.
- R3: In gather (dir_i=1), the k-th accepted sample has lane_o = k[9:7], offset_o = k[6:0] and shared_addr_o = base + bitrev10(k).
- R4: The sample index advances by exactly one per cycle in which valid_o and ready_i are both 1. With ready_i at 0, all outputs hold their values, and there is no gap between samples while ready_i stays at 1.
- R5: done_o is 1 for exactly one cycle, in the cycle after the 1024th sample is accepted. In that same cycle valid_o returns to 0.
- R6: A start pulse while a transfer is in progress has no effect on the sequence, the direction or the base.
- R7: The base and direction are captured on the accepted start pulse. Changing frame_base_i or dir_i during a transfer has no effect on the outputs.
- R8: In one transfer, every lane is addressed exactly 128 times.
- R9: The first sample of a transfer (k = 0) is offered in the cycle after the accepted start pulse. A start pulse in the same cycle as done_o is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one frame transfer |
| dir_i | input | 1 | 0 = scatter (shared to lanes), 1 = gather (lanes to shared) |
| frame_base_i | input | 16 | Shared-buffer base address of the frame |
| ready_i | input | 1 | Consumer accepts the offered sample |
| valid_o | output | 1 | A sample address triple is offered |
| shared_addr_o | output | 16 | Shared-buffer address |
| lane_o | output | 3 | Lane index |
| offset_o | output | 7 | Offset inside the lane memory |
| done_o | output | 1 | One-cycle pulse after the last sample is accepted |

## Verification
The bench runs the following transfers and compares them cycle by cycle against a behavioural model:

- A scatter with ready held at 1. This shows whether bit reversal and the lane/offset split are correct, and whether samples come with no gaps.
- A gather with ready alternating. This separates the sequential lane walk from the reversed shared walk, and exposes stall handling.
- A transfer with a pseudo-random ready pattern, a nonzero base, and a start pulse, base change and direction change injected mid-frame. This shows whether the captured base and direction are kept and whether extra start pulses are ignored.
- Back-to-back starts. These check the timing of the done pulse.

The per-lane counts at the end of a scatter confirm that every lane receives exactly 128 samples.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;
  typedef enum logic {
    DIR_SCATTER = 1'b0,
    DIR_GATHER  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/brd_seq.sv
module brd_seq #(
  parameter int IDX_W = 10,
  parameter int AW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  dir_i,
  input  logic [AW-1:0]         base_i,
  input  logic                  ready_i,
  output logic                  busy_o,
  output logic [IDX_W-1:0]      idx_o,
  output bitrev_pkg::xfer_dir_e dir_o,
  output logic [AW-1:0]         base_o,
  output logic                  done_o
);
  import bitrev_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  logic            busy_q, done_q;
  logic [IDX_W-1:0] idx_q;
  xfer_dir_e       dir_q;
  logic [AW-1:0]   base_q;

  // named internal events
  logic accept_w, last_accept_w, launch_w;
  assign accept_w      = busy_q && ready_i;
  assign last_accept_w = accept_w && (idx_q == LAST_IDX);
  assign launch_w      = !busy_q && start_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      dir_q  <= DIR_SCATTER;
      base_q <= '0;
    end else begin
      done_q <= last_accept_w;
      if (launch_w) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        dir_q  <= xfer_dir_e'(dir_i);
        base_q <= base_i;
      end else if (last_accept_w) begin
        busy_q <= 1'b0;
      end else if (accept_w) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign dir_o  = dir_q;
  assign base_o = base_q;
  assign done_o = done_q;

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ready_i) |=> (busy_q && $stable(idx_q)));
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !last_accept_w) |=> (idx_q == $past(idx_q) + 1'b1));
  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  a_r6_hold_context: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(base_q) && $stable(dir_q)));
endmodule

// File: rtl/brd_map.sv
module brd_map #(
  parameter int IDX_W  = 10,
  parameter int LANE_W = 3,
  parameter int AW     = 16
) (
  input  logic [IDX_W-1:0]      idx_i,
  input  bitrev_pkg::xfer_dir_e dir_i,
  input  logic [AW-1:0]         base_i,
  output logic [AW-1:0]         shared_addr_o,
  output logic [LANE_W-1:0]     lane_o,
  output logic [IDX_W-LANE_W-1:0] offset_o
);
  import bitrev_pkg::*;

  localparam int OFS_W = IDX_W - LANE_W;

  logic [IDX_W-1:0] rev_w;
  for (genvar g = 0; g < IDX_W; g++) begin : g_rev
    assign rev_w[g] = idx_i[IDX_W-1-g];
  end

  function automatic logic [AW-1:0] add_base(input logic [AW-1:0] b,
                                             input logic [IDX_W-1:0] v);
    return b + AW'(v);
  endfunction

  logic [IDX_W-1:0] lane_side_w, shared_side_w;
  assign lane_side_w   = (dir_i == DIR_SCATTER) ? rev_w : idx_i;
  assign shared_side_w = (dir_i == DIR_SCATTER) ? idx_i : rev_w;

  assign shared_addr_o = add_base(base_i, shared_side_w);
  assign lane_o        = lane_side_w[IDX_W-1 -: LANE_W];
  assign offset_o      = lane_side_w[OFS_W-1:0];
endmodule

// File: rtl/bitrev_distributor.sv
module bitrev_distributor #(
  parameter int FRAME_PTS = 1024,
  parameter int LANES     = 8,
  parameter int AW        = 16,
  localparam int IDX_W    = $clog2(FRAME_PTS),
  localparam int LANE_W   = $clog2(LANES),
  localparam int OFS_W    = IDX_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [AW-1:0]     frame_base_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [AW-1:0]     shared_addr_o,
  output logic [LANE_W-1:0] lane_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic              done_o
);
  import bitrev_pkg::*;

  logic             busy_w;
  logic [IDX_W-1:0] idx_w;
  xfer_dir_e        dir_w;
  logic [AW-1:0]    base_w;

  brd_seq #(.IDX_W(IDX_W), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .base_i(frame_base_i), .ready_i(ready_i), .busy_o(busy_w),
    .idx_o(idx_w), .dir_o(dir_w), .base_o(base_w), .done_o(done_o)
  );

  brd_map #(.IDX_W(IDX_W), .LANE_W(LANE_W), .AW(AW)) u_map (
    .idx_i(idx_w), .dir_i(dir_w), .base_i(base_w),
    .shared_addr_o(shared_addr_o), .lane_o(lane_o), .offset_o(offset_o)
  );

  assign valid_o = busy_w;

  a_r1_done_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);
  a_r4_outputs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(shared_addr_o) &&
                               $stable(lane_o) && $stable(offset_o)));
endmodule

// File: tb/test_bitrev_distributor.sv
module test_bitrev_distributor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, dir_i = 1'b0, ready_i = 1'b0;
  logic [15:0] frame_base_i = '0;
  logic valid_o, done_o;
  logic [15:0] shared_addr_o;
  logic [2:0] lane_o;
  logic [6:0] offset_o;

  always #5 clk = ~clk;

  bitrev_distributor i_bitrev_distributor (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .frame_base_i(frame_base_i), .ready_i(ready_i), .valid_o(valid_o),
    .shared_addr_o(shared_addr_o), .lane_o(lane_o), .offset_o(offset_o),
    .done_o(done_o)
  );

  int total = 0, bad = 0, cycles = 0;
  bit m_busy = 0, m_done = 0, m_dir = 0;
  int m_k = 0, m_base = 0;
  int lane_cnt[8];
  bit check_en = 0;

  function automatic int brev(int v);
    int r = 0;
    for (int i = 0; i < 10; i++) begin
      r = (r << 1) | (v & 1);
      v = v >> 1;
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: compare, then advance on the values seen before the next edge
  always @(negedge clk) begin
    cycles++;
    if (check_en) begin
      chk(valid_o == m_busy, "R1/R5/R6/R9 valid", valid_o, m_busy);
      chk(done_o == m_done, "R5 done", done_o, m_done);
      if (m_busy && valid_o) begin
        int ln, of, sa;
        if (!m_dir) begin
          sa = (m_base + m_k) & 16'hFFFF;
          ln = brev(m_k) / 128; of = brev(m_k) % 128;
        end else begin
          sa = (m_base + brev(m_k)) & 16'hFFFF;
          ln = m_k / 128; of = m_k % 128;
        end
        chk(shared_addr_o == sa, m_dir ? "R3/R7 shared" : "R2/R7 shared", shared_addr_o, sa);
        chk(lane_o == ln, m_dir ? "R3 lane" : "R2 lane", lane_o, ln);
        chk(offset_o == of, m_dir ? "R3 offset" : "R2 offset", offset_o, of);
      end
      m_done = 0;
      if (m_busy && ready_i) begin
        lane_cnt[lane_o]++;
        if (m_k == 1023) begin m_busy = 0; m_done = 1; end
        else m_k++;
      end else if (!m_busy && start_i) begin
        m_busy = 1; m_k = 0; m_dir = dir_i; m_base = frame_base_i;
      end
    end
  end

  task automatic run_frame(bit d, int base, int mode, bit disturb, bit chain);
    int lf = 32'h1d3;
    @(posedge clk); #1;
    start_i = 1; dir_i = d; frame_base_i = 16'(base);
    for (int l = 0; l < 8; l++) lane_cnt[l] = 0;
    @(posedge clk); #1;
    start_i = 0;
    for (int c = 0; c < 5000; c++) begin
      if (mode == 0) ready_i = 1;
      else if (mode == 1) ready_i = c[0];
      else begin lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0); ready_i = lf[0] | lf[3]; end
      if (disturb && c == 300) begin start_i = 1; dir_i = ~d; frame_base_i = 16'h7777; end
      if (disturb && c == 301) start_i = 0;
      @(posedge clk); #1;
      if (done_o) break;
    end
    ready_i = 0;
    chk(done_o == 1, "R5 done reached", done_o, 1);
    for (int l = 0; l < 8; l++) chk(lane_cnt[l] == 128, "R8 lane count", lane_cnt[l], 128);
    if (chain) begin
      start_i = 1; dir_i = 0; frame_base_i = 16'h0400;
      @(posedge clk); #1;
      start_i = 0;
      chk(valid_o == 1, "R9 start during done", valid_o, 1);
      ready_i = 1;
      for (int c = 0; c < 2000; c++) begin
        @(posedge clk); #1;
        if (done_o) break;
      end
      ready_i = 0;
      chk(done_o == 1, "R9 chained frame done", done_o, 1);
    end
    @(posedge clk); #1;
    chk(done_o == 0, "R5 single pulse", done_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(valid_o == 0, "R1 reset valid", valid_o, 0);
    chk(done_o == 0, "R1 reset done", done_o, 0);
    rst_n = 1; check_en = 1;
    repeat (4) @(posedge clk);
    run_frame(0, 0, 0, 0, 0);          // R2 R4 R8 scatter, no gaps
    run_frame(1, 16'h0800, 1, 0, 0);   // R3 R4 gather with stalls
    run_frame(0, 16'hFE10, 2, 1, 0);   // R6 R7 disturbances, wrapping base
    run_frame(1, 16'h1000, 2, 1, 1);   // R9 chained start on done
    repeat (5) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule